// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Transmitter

This block sends a two-channel audio stream one bit at a time, most significant bit first, as the slave of three framing signals that come from outside: a bit clock, a left/right clock and a word clock. All three are brought into the system clock domain by synchronizers. The block acts on edges of the synchronized bit clock, so the bit clock may stop and restart at any time. A stereo pair of 24-bit two's-complement samples is handed over through a valid/ready load port. The pair is held in the block until the left/right clock starts a new frame. Both channels of that frame then come from the same pair.

Two static inputs set the framing. A polarity select chooses which bit clock edge the receiver samples on; the transmitter changes data on the other edge. A two-bit format select chooses one of four framings. Three of them place the word relative to the left/right transition, with a lead of 0, 1 or 16 bit slots. The fourth starts each word at a rising edge of the word clock. A mute input is captured at each frame start. When it is captured high, the whole frame goes out as zeros. A receiver may stop reading after any number of leading bits. After the last bit of a word the line stays at zero.

Top module: `stereo_serial_tx`

## Requirements
- R1: After reset, `sdata` is 0 and `in_ready` is 1.
- R2: A pair is accepted on a system clock where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the next frame start, which takes the pair for both channels of that frame. A frame start is a launch edge at which `lr_clk` is first seen low after having been high. Low on `lr_clk` means left; high means right.
- R3: A frame that starts with no pair pending transmits zeros on both channels.
- R4: With `pol_sel`=0, `sdata` changes only after falling edges of `bit_clk` and holds across rising edges. With `pol_sel`=1 both edges are swapped. The edge on which data changes is the launch edge. Slot 0 of a channel is the launch edge at which `lr_clk` is first seen at that channel's level.
- R5: With `fmt_sel`=2'b00, bit 23 of the word goes out in slot 0. Bits 22 down to 0 follow, one per slot.
- R6: With `fmt_sel`=2'b01, slot 0 carries 0 and bit 23 goes out in slot 1.
- R7: With `fmt_sel`=2'b10, slots 0 to 15 carry 0 and bit 23 goes out in slot 16.
- R8: With `fmt_sel`=2'b11, a word starts at the first launch edge at which `word_clk` is seen high after being low. Bit 23 goes out on that edge. The word belongs to the channel given by the `lr_clk` level at that edge. Edges of `lr_clk` do not start words in this format.
- R9: After bit 0 of a word, `sdata` is 0 until the next word starts.
- R10: `mute_in` is sampled at frame start. If it is sampled high, both channels of that frame are all zeros. A change of `mute_in` during the frame does not affect that frame.
- R11: Pauses of any length in `bit_clk` between bits leave the transmitted bit sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | External bit clock, may be gated |
| lr_clk | input | 1 | External left/right clock, low = left |
| word_clk | input | 1 | External word clock, used in format 2'b11 |
| pol_sel | input | 1 | Launch edge: 0 = falling, 1 = rising |
| fmt_sel | input | 2 | Framing format select |
| mute_in | input | 1 | Frame mute request |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair register free |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| sdata | output | 1 | Serial data out |

## Verification
The bench aims at slots where the word position changes by format. These are the empty lead slot of format 01, the sixteen empty slots of format 10 together with its last bit in the last slot of a 40-slot channel, and a word-clock start on the very edge that begins the frame. A design that counted one slot early or late would shift every captured word by one bit. One that missed the frame-start case in the word-clock format would send the previous pair. Mute is toggled inside a frame, and frames are run with no pair loaded. A design that sampled mute per bit would send a half-muted frame; one that reused stale samples would repeat old data instead of zeros. The bench also looks at data just after the receiver's edge and runs with long bit clock gaps. A design that launched on the wrong edge would show `sdata` moving there.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ     = 2'b00,
    FMT_LJ_DLY = 2'b01,
    FMT_RJ     = 2'b10,
    FMT_WCLK   = 2'b11
  } fmt_e;
endpackage

// File: rtl/stx_edge_sync.sv
module stx_edge_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw_in,
  output logic [LANES-1:0] cur_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;
    always_comb chain_n = {chain_q[STAGES-2:0], raw_in[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_n;
    end
    assign cur_q[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/stx_pair_buf.sv
module stx_pair_buf #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              frame_start,
  output logic [WORD_W-1:0] left_src,
  output logic [WORD_W-1:0] right_src
);
  logic              pend_q, pend_n;
  logic [WORD_W-1:0] hold_l_q, hold_l_n, hold_r_q, hold_r_n;
  logic [WORD_W-1:0] frm_l_q, frm_l_n, frm_r_q, frm_r_n;
  logic              accept;

  assign in_ready = ~pend_q;
  assign accept   = in_valid & ~pend_q;

  always_comb begin
    hold_l_n = hold_l_q;
    hold_r_n = hold_r_q;
    frm_l_n  = frm_l_q;
    frm_r_n  = frm_r_q;
    pend_n   = pend_q;
    if (frame_start) begin
      frm_l_n = pend_q ? hold_l_q : '0;
      frm_r_n = pend_q ? hold_r_q : '0;
      pend_n  = 1'b0;
    end
    if (accept) begin
      hold_l_n = in_left;
      hold_r_n = in_right;
      pend_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      frm_l_q  <= '0;
      frm_r_q  <= '0;
    end else begin
      pend_q   <= pend_n;
      hold_l_q <= hold_l_n;
      hold_r_q <= hold_r_n;
      frm_l_q  <= frm_l_n;
      frm_r_q  <= frm_r_n;
    end
  end

  // the frame that starts now reads the pending pair directly
  assign left_src  = frame_start ? (pend_q ? hold_l_q : '0) : frm_l_q;
  assign right_src = frm_r_q;

  AST_READY_DROPS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_READY_BACK_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && frame_start) |=> in_ready); // R2
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int WORD_W   = 24,
  parameter int RJ_DELAY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              lr_now,
  input  logic              wc_now,
  input  stx_pkg::fmt_e     fmt,
  input  logic              mute_in,
  input  logic [WORD_W-1:0] left_src,
  input  logic [WORD_W-1:0] right_src,
  output logic              frame_start,
  output logic              sdata
);
  import stx_pkg::*;
  localparam int SLOT_W = $clog2(RJ_DELAY + WORD_W + 2);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              lr_last_q, lr_last_n, wc_last_q, wc_last_n;
  logic              mute_q, mute_n, mute_eff, sdata_q, sdata_n;
  logic [SLOT_W-1:0] slot_q, slot_n, lead, rel;
  logic [WORD_W-1:0] word_q, word_n, shifted;
  logic              word_start, in_win;

  always_comb begin
    frame_start = launch & lr_last_q & ~lr_now;
    if (fmt == FMT_WCLK) word_start = launch & wc_now & ~wc_last_q;
    else                 word_start = launch & (lr_now ^ lr_last_q);
    mute_eff = frame_start ? mute_in : mute_q;
    case (fmt)
      FMT_LJ_DLY: lead = SLOT_W'(1);
      FMT_RJ:     lead = SLOT_W'(RJ_DELAY);
      default:    lead = '0;
    endcase
  end

  always_comb begin
    lr_last_n = launch ? lr_now : lr_last_q;
    wc_last_n = launch ? wc_now : wc_last_q;
    mute_n    = frame_start ? mute_in : mute_q;
    slot_n    = slot_q;
    word_n    = word_q;
    if (word_start) begin
      slot_n = '0;
      word_n = mute_eff ? '0 : (lr_now ? right_src : left_src);
    end else if (launch && slot_q != SLOT_MAX) begin
      slot_n = slot_q + 1'b1;
    end
    rel     = slot_n - lead;
    in_win  = (slot_n >= lead) && (rel < SLOT_W'(WORD_W));
    shifted = word_n << rel;
    sdata_n = launch ? (in_win & shifted[WORD_W-1]) : sdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_last_q <= 1'b1;
      wc_last_q <= 1'b0;
      mute_q    <= 1'b0;
      slot_q    <= SLOT_MAX;
      word_q    <= '0;
      sdata_q   <= 1'b0;
    end else begin
      lr_last_q <= lr_last_n;
      wc_last_q <= wc_last_n;
      mute_q    <= mute_n;
      slot_q    <= slot_n;
      word_q    <= word_n;
      sdata_q   <= sdata_n;
    end
  end

  assign sdata = sdata_q;

  AST_HOLD_BETWEEN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdata_q)); // R4
  AST_MUTED_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && mute_eff) |=> (word_q == '0 && !sdata_q)); // R10
  AST_DELAY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && fmt == FMT_LJ_DLY) |=> !sdata_q); // R6
  AST_RJ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_start && fmt == FMT_RJ) |=> !sdata_q); // R7
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int WORD_W      = 24,
  parameter int RJ_DELAY    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              lr_clk,
  input  logic              word_clk,
  input  logic              pol_sel,
  input  logic [1:0]        fmt_sel,
  input  logic              mute_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  output logic              sdata
);
  logic [1:0]        rst_pipe_q;
  logic              irst_n;
  logic [2:0]        synced;
  logic              bclk_prev_q, launch, frame_start;
  logic [WORD_W-1:0] left_src, right_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign irst_n = rst_pipe_q[1];

  stx_edge_sync #(.STAGES(SYNC_STAGES), .LANES(3)) u_sync (
    .clk(clk), .rst_n(irst_n),
    .raw_in({word_clk, lr_clk, bit_clk}),
    .cur_q(synced)
  );

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= synced[0];
  end
  assign launch = pol_sel ? (synced[0] & ~bclk_prev_q) : (~synced[0] & bclk_prev_q);

  stx_pair_buf #(.WORD_W(WORD_W)) u_buf (
    .clk(clk), .rst_n(irst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .frame_start(frame_start),
    .left_src(left_src), .right_src(right_src)
  );

  stx_shifter #(.WORD_W(WORD_W), .RJ_DELAY(RJ_DELAY)) u_shift (
    .clk(clk), .rst_n(irst_n),
    .launch(launch), .lr_now(synced[1]), .wc_now(synced[2]),
    .fmt(stx_pkg::fmt_e'(fmt_sel)), .mute_in(mute_in),
    .left_src(left_src), .right_src(right_src),
    .frame_start(frame_start), .sdata(sdata)
  );
endmodule

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
  localparam int W = 24;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bit_clk, lr_clk, word_clk, pol_sel, mute_in, in_valid, in_ready, sdata;
  logic [1:0] fmt_sel;
  logic [W-1:0] in_left, in_right;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int gap_max = 4;
  logic [63:0] cap;
  bit glitch;

  stereo_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .lr_clk(lr_clk), .word_clk(word_clk),
    .pol_sel(pol_sel), .fmt_sel(fmt_sel), .mute_in(mute_in), .in_valid(in_valid),
    .in_ready(in_ready), .in_left(in_left), .in_right(in_right), .sdata(sdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int start_of(input logic [1:0] m, input int wofs);
    case (m)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 16;
      default: return wofs;
    endcase
  endfunction

  function automatic logic [63:0] exp_vec(input logic [W-1:0] s, input bit mute,
                                          input int st, input int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++)
      if (!mute && k >= st && k < st + W) v[k] = s[W-1-(k-st)];
    return v;
  endfunction

  task automatic slot_step(input int idx, input logic lr_v, input logic wc_v);
    @(negedge clk);
    bit_clk = pol_sel; lr_clk = lr_v; word_clk = wc_v;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk);
    cap[idx] = sdata;
    bit_clk = ~pol_sel;
    repeat (HALF - 2) @(negedge clk);
    if (sdata !== cap[idx]) glitch = 1;
    repeat ($urandom % gap_max) @(negedge clk);
  endtask

  task automatic run_channel(input logic lr_v, input int n, input int wofs);
    cap = '0;
    for (int i = 0; i < n; i++)
      slot_step(i, lr_v, (fmt_sel == 2'b11) && (i == wofs));
  endtask

  task automatic run_frame(input logic [1:0] m, input logic pol, input bit mute,
                           input bit doload, input logic [W-1:0] l, input logic [W-1:0] r,
                           input int wofs, input int extra, input bit mute_mid,
                           input string tag);
    int st, n;
    string req;
    logic [63:0] e;
    st = start_of(m, wofs);
    n = st + W + extra;
    if (tag != "") req = tag;
    else if (mute) req = "R10";
    else if (!doload) req = "R3";
    else case (m)
      2'b00: req = "R5";
      2'b01: req = "R6";
      2'b10: req = "R7";
      default: req = "R8";
    endcase
    @(negedge clk);
    if (pol_sel !== pol) begin
      pol_sel = pol; bit_clk = ~pol;
      repeat (4) @(negedge clk);
    end
    fmt_sel = m; mute_in = mute;
    if (doload) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(negedge clk);
      in_valid = 1'b0; in_left = $urandom; in_right = $urandom;
      @(negedge clk);
      check(in_ready == 1'b0, "R2", "ready after load", 64'(in_ready), 64'd0);
    end
    glitch = 0;
    run_channel(1'b0, n, wofs);
    e = exp_vec(doload ? l : '0, mute, st, n);
    check(cap == e, req, "left channel bits", cap, e);
    check((cap >> (st + W)) == 64'd0, "R9", "left tail zeros", cap >> (st + W), 64'd0);
    if (doload) check(in_ready == 1'b1, "R2", "ready after frame start", 64'(in_ready), 64'd1);
    if (mute_mid) mute_in = ~mute;
    run_channel(1'b1, n, wofs);
    e = exp_vec(doload ? r : '0, mute, st, n);
    check(cap == e, req, "right channel bits", cap, e);
    check((cap >> (st + W)) == 64'd0, "R9", "right tail zeros", cap >> (st + W), 64'd0);
    check(glitch == 0, "R4", "data moved after receiver edge", 64'(glitch), 64'd0);
    mute_in = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0; bit_clk = 1'b1; lr_clk = 1'b1; word_clk = 1'b0; pol_sel = 1'b0;
    fmt_sel = 2'b00; mute_in = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sdata == 1'b0, "R1", "sdata after reset", 64'(sdata), 64'd0);
    check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
    // warm-up slots on the right channel level
    run_channel(1'b1, 4, 0);

    run_frame(2'b00, 1'b0, 0, 1, 24'h8F0F35, 24'h5A5A5A, 0, 3, 0, "");
    run_frame(2'b01, 1'b0, 0, 1, 24'hC00001, 24'h7FFFFF, 0, 2, 0, "");
    run_frame(2'b10, 1'b1, 0, 1, 24'hFFFFFF, 24'h800001, 0, 0, 0, "");   // last bit in slot 39
    run_frame(2'b11, 1'b1, 0, 1, 24'h123456, 24'hABCDEF, 0, 2, 0, "");   // word on frame edge
    run_frame(2'b11, 1'b0, 0, 1, 24'hFEDCBA, 24'h0F1E2D, 3, 1, 0, "");
    run_frame(2'b00, 1'b0, 0, 0, 24'h111111, 24'h222222, 0, 2, 0, "");   // no pair: R3
    run_frame(2'b01, 1'b1, 1, 1, 24'hFFFFFF, 24'hFFFFFF, 0, 1, 1, "");   // muted, released mid frame
    run_frame(2'b10, 1'b0, 0, 1, 24'hA5C3E1, 24'h3C5A7E, 0, 2, 1, "R10"); // mute raised mid frame
    gap_max = 40;
    run_frame(2'b00, 1'b1, 0, 1, 24'h9ABCDE, 24'h13579B, 0, 1, 0, "R11");
    run_frame(2'b11, 1'b0, 0, 1, 24'h2468AC, 24'hFDB975, 2, 1, 0, "R11");
    gap_max = 4;

    for (int f = 0; f < 30; f++) begin
      logic [1:0] m;
      m = 2'($urandom % 4);
      run_frame(m, 1'($urandom % 2), ($urandom % 8) == 0, ($urandom % 10) != 0,
                W'($urandom), W'($urandom), $urandom % 6, $urandom % 5,
                ($urandom % 4) == 0, "");
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule